// File: doc/BRIEF.md
# Group-Owned GPIO Register Bank

This block is a bank of 32 general-purpose pins controlled through a word-wide register bus. The pins are split into four groups of eight. Every group has an owner, which is one of up to four bus masters chosen by a two-bit code. Each bus write carries the ID of the master that issued it. In the configuration and data registers, a write changes only the byte lanes whose group is owned by that master. The other lanes keep their old contents. This lets several agents share one bank without a read-modify-write race on each other's pins.

A write to the data register goes into an output latch. The visible pin level of an output pin (direction bit 1) follows that latch one cycle later. The level of an input pin (direction bit 0) follows the external pin through a two-stage synchronizer. Setting a bit in the freeze mask holds that pin's visible level. The interrupt-enable, sensitivity, status, hold-over-reset and debounce-select registers are storage only. Two build-time masks give the pins that exist as inputs and as outputs. All write data is trimmed to their union.

Top module: `gpio_owned_bank`

Register offsets, as byte addresses with the low two bits zero: 0x00 pin level (a write goes to the latch), 0x04 latch readback, 0x08 direction, 0x0C freeze mask, 0x10 interrupt enable, 0x14/0x18/0x1C sensitivity 0/1/2, 0x20 interrupt status, 0x24 hold-over-reset, 0x28/0x2C debounce select 0/1, 0x30 owner-code low, 0x34 owner-code high.

## Requirements
- R1: After reset every register reads zero, pin_out and pin_oe are zero, and so all four groups belong to master 0.
- R2: The owner code of group g (bits 8g+7:8g) is {bit 8g of 0x34, bit 8g of 0x30}. Only bits 0, 8, 16 and 24 of 0x30 and 0x34 can be written. All their other bits read zero.
- R3: Writes to 0x00, 0x08, 0x10, 0x14, 0x18, 0x1C, 0x24, 0x28 and 0x2C change only the byte lanes whose owner code equals req_master. Every other lane keeps its value.
- R4: Before any write is applied, the write data is ANDed with VALID_IN | VALID_OUT.
- R5: A write to the freeze mask at 0x0C is not gated by lane ownership. It stores only the bits set in VALID_IN.
- R6: The output latch reads back at 0x04, which is read-only. A write there changes nothing.
- R7: When direction is 1 and the mask bit is 0, the level bit takes the latch value one clock after the latch changes. pin_out shows the level and pin_oe shows the direction register.
- R8: When direction is 0 and the mask bit is 0, the level bit takes the value pin_in had three rising edges earlier.
- R9: When a mask bit is 1, that level bit does not change.
- R10: Only accesses with req_size = 2'b10 (32-bit) take effect. A read of another size returns zero, and a write of another size changes nothing.
- R11: A read of an unmapped or unaligned address returns zero. A write to one changes nothing.
- R12: Read data is on rsp_rdata in the cycle after the request. In any cycle with no read request the previous cycle, rsp_rdata is zero.
- R13: A write to the status register at 0x20 is stored in full (after R4), with no lane gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size; 2'b10 = 32-bit |
| req_master | input | 2 | ID of the requesting master |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| pin_in | input | 32 | External pin levels (asynchronous) |
| pin_out | output | 32 | Driven pin values |
| pin_oe | output | 32 | Output enables |

## Verification
Writes from each master go to registers whose lanes have been handed to masters in several mixes, from all groups owned by one master to a different owner per lane. This separates correct lane gating from gating that is missing or inverted. Data that is all ones, together with the default valid masks (bits 7:4 absent), separates the valid-pin trimming from the ownership gating. Pin tests first toggle the latch on output pins and the external level on input pins, then repeat this under a freeze mask, to show the latch path, the synchronizer path and freezing separately. Short-size, unaligned and unmapped accesses, mixed into the random traffic, show that they are ignored.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BANK_W = 32;
    localparam int GRP_W  = 8;
    localparam int NUM_GRP = BANK_W / GRP_W;
    localparam int IDX_W  = 4;

    localparam logic [1:0] SIZE_WORD = 2'b10;

    typedef enum logic [IDX_W-1:0] {
        IDX_LEVEL = 4'd0,
        IDX_LATCH = 4'd1,
        IDX_DIR   = 4'd2,
        IDX_MASK  = 4'd3,
        IDX_IEN   = 4'd4,
        IDX_SENS0 = 4'd5,
        IDX_SENS1 = 4'd6,
        IDX_SENS2 = 4'd7,
        IDX_STAT  = 4'd8,
        IDX_RTOL  = 4'd9,
        IDX_DEB0  = 4'd10,
        IDX_DEB1  = 4'd11,
        IDX_SRC0  = 4'd12,
        IDX_SRC1  = 4'd13
    } reg_idx_e;

    typedef struct packed {
        logic [BANK_W-1:0] latch;
        logic [BANK_W-1:0] level;
        logic [BANK_W-1:0] dir;
        logic [BANK_W-1:0] mask;
        logic [BANK_W-1:0] ien;
        logic [BANK_W-1:0] sens0;
        logic [BANK_W-1:0] sens1;
        logic [BANK_W-1:0] sens2;
        logic [BANK_W-1:0] stat;
        logic [BANK_W-1:0] rtol;
        logic [BANK_W-1:0] deb0;
        logic [BANK_W-1:0] deb1;
        logic [BANK_W-1:0] src0;
        logic [BANK_W-1:0] src1;
    } bank_regs_t;

    typedef struct packed {
        bank_regs_t        regs;
        logic [BANK_W-1:0] sync1;
        logic [BANK_W-1:0] sync2;
        logic [BANK_W-1:0] rdata;
    } bank_state_t;

    // One writable owner bit at the bottom of every group
    function automatic logic [BANK_W-1:0] owner_bits();
        logic [BANK_W-1:0] r;
        r = '0;
        for (int g = 0; g < NUM_GRP; g++) r[g*GRP_W] = 1'b1;
        return r;
    endfunction

    function automatic logic [BANK_W-1:0] lane_merge(
        input logic [BANK_W-1:0] old_v,
        input logic [BANK_W-1:0] new_v,
        input logic [BANK_W-1:0] lanes
    );
        return (old_v & ~lanes) | (new_v & lanes);
    endfunction

endpackage

// File: rtl/gpio_lane_owner.sv
module gpio_lane_owner
    import gpio_bank_pkg::*;
(
    input  logic [BANK_W-1:0] src0,
    input  logic [BANK_W-1:0] src1,
    input  logic [1:0]        master,
    output logic [BANK_W-1:0] lanes
);
    // Expand each group's ownership match to a full byte-lane enable
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [1:0] code;
        assign code = {src1[g*GRP_W], src0[g*GRP_W]};
        assign lanes[g*GRP_W +: GRP_W] = {GRP_W{code == master}};
    end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_bank_pkg::*;
(
    input  bank_regs_t        regs,
    input  logic [IDX_W-1:0]  idx,
    input  logic              hit,
    output logic [BANK_W-1:0] data
);
    always_comb begin
        data = '0;
        if (hit) begin
            case (reg_idx_e'(idx))
                IDX_LEVEL: data = regs.level;
                IDX_LATCH: data = regs.latch;
                IDX_DIR:   data = regs.dir;
                IDX_MASK:  data = regs.mask;
                IDX_IEN:   data = regs.ien;
                IDX_SENS0: data = regs.sens0;
                IDX_SENS1: data = regs.sens1;
                IDX_SENS2: data = regs.sens2;
                IDX_STAT:  data = regs.stat;
                IDX_RTOL:  data = regs.rtol;
                IDX_DEB0:  data = regs.deb0;
                IDX_DEB1:  data = regs.deb1;
                IDX_SRC0:  data = regs.src0;
                IDX_SRC1:  data = regs.src1;
                default:   data = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_owned_bank.sv
module gpio_owned_bank
    import gpio_bank_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [BANK_W-1:0] VALID_IN  = 32'hFFFF_FF0F,
    parameter logic [BANK_W-1:0] VALID_OUT = 32'h0FFF_FF0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [1:0]        req_master,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BANK_W-1:0] req_wdata,
    output logic [BANK_W-1:0] rsp_rdata,
    input  logic [BANK_W-1:0] pin_in,
    output logic [BANK_W-1:0] pin_out,
    output logic [BANK_W-1:0] pin_oe
);
    localparam int                IDX_LO   = 2;
    localparam int                IDX_HI   = IDX_LO + IDX_W - 1;
    localparam logic [BANK_W-1:0] WR_KEEP  = VALID_IN | VALID_OUT;
    localparam logic [BANK_W-1:0] SRC_KEEP = owner_bits();
    localparam int                NUM_REGS = 14;

    bank_state_t       q, d;
    logic [BANK_W-1:0] lanes;
    logic [BANK_W-1:0] rd_word;
    logic              hit;
    logic [IDX_W-1:0]  idx;

    assign idx = req_addr[IDX_HI:IDX_LO];

    // Word-aligned, inside the decoded window, and a defined register
    always_comb begin
        hit = (req_addr[IDX_LO-1:0] == '0) && (32'(idx) < NUM_REGS);
        if (ADDR_W > IDX_HI + 1) begin
            for (int b = IDX_HI + 1; b < ADDR_W; b++) begin
                if (req_addr[b]) hit = 1'b0;
            end
        end
    end

    gpio_lane_owner u_owner (
        .src0   (q.regs.src0),
        .src1   (q.regs.src1),
        .master (req_master),
        .lanes  (lanes)
    );

    gpio_read_mux u_rmux (
        .regs (q.regs),
        .idx  (idx),
        .hit  (hit),
        .data (rd_word)
    );

    always_comb begin
        logic              wr_ok;
        logic              rd_ok;
        logic [BANK_W-1:0] wclean;

        d      = q;
        wr_ok  = req_valid && req_write && (req_size == SIZE_WORD) && hit;
        rd_ok  = req_valid && !req_write && (req_size == SIZE_WORD);
        wclean = req_wdata & WR_KEEP;

        // Input synchronizer
        d.sync1 = pin_in;
        d.sync2 = q.sync1;

        // Visible level: frozen, from latch, or from synchronized pin
        d.regs.level = (q.regs.mask & q.regs.level)
                     | (~q.regs.mask & ((q.regs.dir & q.regs.latch)
                                      | (~q.regs.dir & q.sync2)));

        if (wr_ok) begin
            case (reg_idx_e'(idx))
                IDX_LEVEL: d.regs.latch = lane_merge(q.regs.latch, wclean, lanes);
                IDX_DIR:   d.regs.dir   = lane_merge(q.regs.dir,   wclean, lanes);
                IDX_MASK:  d.regs.mask  = wclean & VALID_IN;
                IDX_IEN:   d.regs.ien   = lane_merge(q.regs.ien,   wclean, lanes);
                IDX_SENS0: d.regs.sens0 = lane_merge(q.regs.sens0, wclean, lanes);
                IDX_SENS1: d.regs.sens1 = lane_merge(q.regs.sens1, wclean, lanes);
                IDX_SENS2: d.regs.sens2 = lane_merge(q.regs.sens2, wclean, lanes);
                IDX_STAT:  d.regs.stat  = wclean;
                IDX_RTOL:  d.regs.rtol  = lane_merge(q.regs.rtol,  wclean, lanes);
                IDX_DEB0:  d.regs.deb0  = lane_merge(q.regs.deb0,  wclean, lanes);
                IDX_DEB1:  d.regs.deb1  = lane_merge(q.regs.deb1,  wclean, lanes);
                IDX_SRC0:  d.regs.src0  = wclean & SRC_KEEP;
                IDX_SRC1:  d.regs.src1  = wclean & SRC_KEEP;
                default:   ; // latch readback is read-only
            endcase
        end

        d.rdata = rd_ok ? rd_word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_rdata = q.rdata;
    assign pin_out   = q.regs.level;
    assign pin_oe    = q.regs.dir;

endmodule

// File: rtl/gpio_owned_bank_chk.sv
module gpio_owned_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [BANK_W-1:0] VALID_IN  = 32'hFFFF_FF0F,
    parameter logic [BANK_W-1:0] VALID_OUT = 32'h0FFF_FF0F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_size,
    input logic [1:0]        req_master,
    input logic [ADDR_W-1:0] req_addr,
    input logic [BANK_W-1:0] rsp_rdata,
    input logic [BANK_W-1:0] dir_q,
    input logic [BANK_W-1:0] mask_q,
    input logic [BANK_W-1:0] level_q,
    input logic [BANK_W-1:0] src0_q,
    input logic [BANK_W-1:0] src1_q
);
    localparam logic [BANK_W-1:0] SRCM   = owner_bits();
    localparam logic [ADDR_W-1:0] DIR_AD = ADDR_W'(8);

    assert_src_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((src0_q | src1_q) & ~SRCM) == '0);

    assert_dir_trim_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q & ~(VALID_IN | VALID_OUT)) == '0);

    assert_mask_trim_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q & ~VALID_IN) == '0);

    assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((level_q ^ $past(level_q)) & $past(mask_q)) == '0);

    assert_idle_rdata_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> rsp_rdata == '0);

    assert_short_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size != SIZE_WORD) |=> rsp_rdata == '0);

    assert_short_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_size != SIZE_WORD) |=> ($stable(dir_q) && $stable(mask_q)));

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_lane
        assert_foreign_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_write && req_addr == DIR_AD
             && {src1_q[g*GRP_W], src0_q[g*GRP_W]} != req_master)
            |=> $stable(dir_q[g*GRP_W +: GRP_W]));
    end
endmodule

bind gpio_owned_bank gpio_owned_bank_chk #(
    .ADDR_W    (ADDR_W),
    .VALID_IN  (VALID_IN),
    .VALID_OUT (VALID_OUT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_size   (req_size),
    .req_master (req_master),
    .req_addr   (req_addr),
    .rsp_rdata  (rsp_rdata),
    .dir_q      (q.regs.dir),
    .mask_q     (q.regs.mask),
    .level_q    (q.regs.level),
    .src0_q     (q.regs.src0),
    .src1_q     (q.regs.src1)
);

// File: tb/gpio_owned_bank_tb.sv
module gpio_owned_bank_tb;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] VI   = 32'hFFFF_FF0F;
    localparam logic [31:0] VO   = 32'h0FFF_FF0F;
    localparam logic [31:0] SRCM = 32'h0101_0101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'b10, req_master = 2'b00;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0, pin_in = '0;
    logic [31:0] rsp_rdata, pin_out, pin_oe;

    gpio_owned_bank u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_master(req_master), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // Reference state built from the requirements
    logic [31:0] m_latch = 0, m_level = 0, m_dir = 0, m_mask = 0, m_ien = 0;
    logic [31:0] m_s0 = 0, m_s1 = 0, m_s2 = 0, m_stat = 0, m_rtol = 0;
    logic [31:0] m_d0 = 0, m_d1 = 0, m_src0 = 0, m_src1 = 0, m_y1 = 0, m_y2 = 0;

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] lanes_of(logic [1:0] ms);
        logic [31:0] r = '0;
        for (int g = 0; g < 4; g++)
            if ({m_src1[g*8], m_src0[g*8]} == ms) r[g*8 +: 8] = 8'hFF;
        return r;
    endfunction

    function automatic logic [31:0] mread(logic [7:0] a, logic [1:0] sz);
        if (sz != 2'b10) return 0;
        case (a)
            8'h00: return m_level;  8'h04: return m_latch;
            8'h08: return m_dir;    8'h0C: return m_mask;
            8'h10: return m_ien;    8'h14: return m_s0;
            8'h18: return m_s1;     8'h1C: return m_s2;
            8'h20: return m_stat;   8'h24: return m_rtol;
            8'h28: return m_d0;     8'h2C: return m_d1;
            8'h30: return m_src0;   8'h34: return m_src1;
            default: return 0;
        endcase
    endfunction

    task automatic mstep(bit v, bit w, logic [1:0] sz, logic [1:0] ms,
                         logic [7:0] a, logic [31:0] wd, logic [31:0] pin);
        logic [31:0] wc, ln, nlev;
        wc = wd & (VI | VO);
        ln = lanes_of(ms);
        nlev = (m_mask & m_level) | (~m_mask & ((m_dir & m_latch) | (~m_dir & m_y2)));
        m_y2 = m_y1;
        m_y1 = pin;
        if (v && w && sz == 2'b10) begin
            case (a)
                8'h00: m_latch = (m_latch & ~ln) | (wc & ln);
                8'h08: m_dir   = (m_dir & ~ln) | (wc & ln);
                8'h0C: m_mask  = wc & VI;
                8'h10: m_ien   = (m_ien & ~ln) | (wc & ln);
                8'h14: m_s0    = (m_s0 & ~ln) | (wc & ln);
                8'h18: m_s1    = (m_s1 & ~ln) | (wc & ln);
                8'h1C: m_s2    = (m_s2 & ~ln) | (wc & ln);
                8'h20: m_stat  = wc;
                8'h24: m_rtol  = (m_rtol & ~ln) | (wc & ln);
                8'h28: m_d0    = (m_d0 & ~ln) | (wc & ln);
                8'h2C: m_d1    = (m_d1 & ~ln) | (wc & ln);
                8'h30: m_src0  = wc & SRCM;
                8'h34: m_src1  = wc & SRCM;
                default: ;
            endcase
        end
        m_level = nlev;
    endtask

    // One bus cycle; checks read data against the model (R12) and the pins (R7)
    task automatic op(bit v, bit w, logic [1:0] sz, logic [1:0] ms, logic [7:0] a,
                      logic [31:0] wd, string tag, output logic [31:0] rd);
        logic [31:0] exp;
        exp = (v && !w) ? mread(a, sz) : 32'h0;
        req_valid = v; req_write = w; req_size = sz; req_master = ms;
        req_addr = a; req_wdata = wd;
        @(posedge clk);
        mstep(v, w, sz, ms, a, wd, pin_in);
        @(negedge clk);
        req_valid = 1'b0;
        rd = rsp_rdata;
        check(tag, rsp_rdata, exp);
        check("R7 pin_out", pin_out, m_level);
        check("R7 pin_oe", pin_oe, m_dir);
    endtask

    task automatic wr(logic [1:0] ms, logic [7:0] a, logic [31:0] wd, string tag);
        logic [31:0] dummy;
        op(1, 1, 2'b10, ms, a, wd, tag, dummy);
    endtask

    task automatic rd(logic [7:0] a, string tag, output logic [31:0] val);
        op(1, 0, 2'b10, 0, a, 0, tag, val);
    endtask

    task automatic idle(int n, string tag);
        logic [31:0] dummy;
        for (int i = 0; i < n; i++) op(0, 0, 2'b10, 0, 0, 0, tag, dummy);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        check("R1 pin_oe", pin_oe, 0);
        for (int a = 0; a < 14; a++) begin
            rd(8'(a*4), "R1 reset read", v);
            check("R1 zero", v, 0);
        end

        // R2: owner-code bits only
        wr(0, 8'h30, 32'hFFFF_FFFF, "R2");
        rd(8'h30, "R2", v);
        check("R2 owner bits", v, 32'h0101_0101);

        // R3: every group now owned by master 1; master 0 is locked out
        wr(0, 8'h08, 32'hFFFF_FFFF, "R3");
        rd(8'h08, "R3", v);
        check("R3 foreign write", v, 0);
        // R4: owner writes all ones, bits 7:4 trimmed
        wr(1, 8'h08, 32'hFFFF_FFFF, "R4");
        rd(8'h08, "R4", v);
        check("R4 trim", v, 32'hFFFF_FF0F);
        // R3: only group 1 left with master 1
        wr(1, 8'h30, 32'h0000_0100, "R3");
        wr(0, 8'h08, 32'h0000_0000, "R3");
        rd(8'h08, "R3", v);
        check("R3 mixed lanes", v, 32'h0000_FF00);
        wr(0, 8'h30, 32'h0, "R3"); // master 0 may still set owner codes
        wr(0, 8'h08, 32'h0000_000F, "R7");

        // R5: mask trimmed, not gated
        wr(3, 8'h0C, 32'hFFFF_FFFF, "R5");
        rd(8'h0C, "R5", v);
        check("R5 mask", v, VI);
        wr(2, 8'h0C, 32'h0, "R5");

        // R13: status stored by any master
        wr(2, 8'h20, 32'h1234_5678, "R13");
        rd(8'h20, "R13", v);
        check("R13 status", v, 32'h1234_5608);

        // R6 and R7: latch and output level
        wr(0, 8'h00, 32'h0000_0005, "R7");
        rd(8'h04, "R6", v);
        check("R6 latch", v, 32'h5);
        wr(0, 8'h04, 32'hFFFF_FFFF, "R6");
        rd(8'h04, "R6", v);
        check("R6 read-only", v, 32'h5);
        rd(8'h00, "R7", v);
        check("R7 level", v & 32'hF, 32'h5);

        // R8: input path, three edges
        pin_in = 32'hA5A5_0000;
        idle(2, "R8");
        rd(8'h00, "R8", v);
        check("R8 not yet", v & 32'hFFFF_0000, 0);
        idle(1, "R8");
        rd(8'h00, "R8", v);
        check("R8 level", v & 32'hFFFF_0000, 32'hA5A5_0000);

        // R9: frozen inputs and outputs
        wr(0, 8'h0C, 32'hFFFF_000F, "R9");
        pin_in = 32'h5A5A_0000;
        wr(0, 8'h00, 32'h0000_000A, "R9");
        idle(4, "R9");
        rd(8'h00, "R9", v);
        check("R9 frozen", v & 32'hFFFF_000F, 32'hA5A5_0005);
        wr(0, 8'h0C, 32'h0, "R9");

        // R10: short accesses
        op(1, 0, 2'b01, 0, 8'h08, 0, "R10 short read", v);
        check("R10 short read", v, 0);
        op(1, 1, 2'b00, 0, 8'h08, 32'hFFFF_FFFF, "R10", v);
        rd(8'h08, "R10", v);
        check("R10 short write", v, 32'h0000_000F);

        // R11: unmapped and unaligned
        rd(8'h40, "R11", v);
        check("R11 unmapped", v, 0);
        wr(0, 8'h3C, 32'hFFFF_FFFF, "R11");
        wr(0, 8'h49, 32'hFFFF_FFFF, "R11");
        wr(0, 8'h0A, 32'hFFFF_FFFF, "R11");
        rd(8'h08, "R11", v);
        check("R11 no effect", v, 32'h0000_000F);

        // Random traffic checked against the model
        for (int i = 0; i < 3000; i++) begin
            logic [7:0]  a;
            logic [1:0]  sz;
            bit          w;
            a  = ($urandom % 8 == 0) ? 8'($urandom) : 8'(($urandom % 14) * 4);
            sz = ($urandom % 6 == 0) ? 2'($urandom) : 2'b10;
            w  = 1'($urandom);
            if ($urandom % 10 == 0) pin_in = $urandom;
            op(1'($urandom % 5 != 0), w, sz, 2'($urandom), a, $urandom, "random", v);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule